// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block is the receive half of an asynchronous serial port. A two-flop synchroniser feeds the serial line into a sampler. The sampler runs on a baud tick at sixteen times the bit rate. It confirms each start bit, gathers eight data bits least significant first, and can also check a parity bit. It then judges the stop bit. Every finished character is queued together with its own status bits. Because of this, a reader always sees the flags that belong to the character it is looking at, and never the flags of some later character.

A line held low through an entire frame is reported as a line break. This produces a single zero character marked as a break. The receiver then ignores the line until the line has gone back to idle high and a new start bit has been confirmed. A one-cycle error pulse marks every character that has a frame, parity or break fault. A consumer watches the availability flag, reads the 12-bit head word, and pulses the read strobe to pop it.

Top module: `uart_rx_errfifo`

## Requirements
- R1: The serial input passes through two flip-flops. Sampling happens only on baud ticks, with 16 ticks per bit. A start bit counts only if the line is still low 8 ticks after the falling edge was seen; a shorter low pulse queues nothing.
- R2: Data bits are sampled at mid-bit, least significant bit first. The head word carries the data in bits 7:0, and `rx_avail_o` is high while at least one word is queued.
- R3: If the stop bit is sampled low, bit 8 (frame error) of that character's word is set.
- R4: With parity enabled, bit 9 (parity error) is set when the parity bit differs from the expected value. The expected value is: even select gives the XOR of the data bits; odd select gives its inverse; stick mode gives 0 for even select and 1 for odd select. With parity disabled, no parity bit is received and bit 9 stays 0.
- R5: When the line is low at every sample of a frame (start, data, parity if enabled, stop), exactly one word is queued for it. That word has data 0, bit 10 (break) set, bit 8 set and bit 9 clear.
- R6: After any frame whose stop bit was sampled low, no new start bit is accepted until the line has been seen high. A break held low for many more frame times therefore queues nothing more.
- R7: The queue holds 16 words and returns them in arrival order. `rd_data_o` shows the oldest word, and a read strobe while words are available removes that word.
- R8: A character that completes while the queue is full is discarded, and bit 11 (overrun) is set in the most recently stored word.
- R9: `err_o` pulses for exactly one clock for each character that has a frame, parity or break error. Error-free characters give no pulse.
- R10: While reset is asserted, the queue is emptied, and `rd_data_o`, `rx_avail_o` and `err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_i | input | 1 | Serial line, idle high |
| baud_tick_i | input | 1 | Enable pulse at 16 times the bit rate |
| par_en_i | input | 1 | A parity bit follows the data |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| par_stick_i | input | 1 | Parity bit is a constant chosen by par_even_i |
| rd_i | input | 1 | Pop the head word |
| rd_data_o | output | 12 | Head word: {overrun, break, parity err, frame err, data[7:0]}; zero when empty |
| rx_avail_o | output | 1 | Queue not empty |
| err_o | output | 1 | One-cycle pulse per erroneous character |

## Verification
A character's word is pushed, and its error pulse raised, on the clock after the stop-bit sample. That sample falls about two synchroniser cycles plus half a bit after the start of the stop bit. The bench therefore reads the head word only after the full stop bit and one idle bit have passed. It does not predict the exact cycle. Error pulses are counted over the whole frame window and compared with the expected count for that character. Outputs are sampled on falling clock edges, and reads are strobed for one clock, so each pop is visible at the next falling edge.

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo #(
  parameter int OVS   = 16,
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_i,
  input  logic        baud_tick_i,
  input  logic        par_en_i,
  input  logic        par_even_i,
  input  logic        par_stick_i,
  input  logic        rd_i,
  output logic [11:0] rd_data_o,
  output logic        rx_avail_o,
  output logic        err_o
);
  // OVS and DEPTH must be powers of two
  localparam int CW = $clog2(OVS);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [1:0]    sync_q;
  logic          rx_s;
  st_t           st;
  logic [CW-1:0] tcnt;
  logic [2:0]    bitn;
  logic [7:0]    shr;
  logic          par_q, locked, allz;

  logic [11:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   count;

  logic done, fe, brk, pe, par_exp, full, push, ovr, pop, idle;
  logic [11:0] word;

  assign rx_s    = sync_q[1];
  assign idle    = (st == S_IDLE);
  assign par_exp = par_stick_i ? ~par_even_i : (par_even_i ? ^shr : ~(^shr));
  assign done    = baud_tick_i && (st == S_STOP) && (tcnt == LAST);
  assign fe      = !rx_s;
  assign brk     = fe && allz;
  assign pe      = par_en_i && !brk && (par_q != par_exp);
  assign word    = {1'b0, brk, pe, fe, shr};

  assign full = (count == (AW+1)'(DEPTH));
  assign push = done && !full;
  assign ovr  = done && full;
  assign pop  = rd_i && (count != '0);

  assign rx_avail_o = (count != '0);
  assign rd_data_o  = rx_avail_o ? mem[rp] : 12'h000;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      st     <= S_IDLE;
      tcnt   <= '0;
      bitn   <= '0;
      shr    <= '0;
      par_q  <= 1'b0;
      locked <= 1'b0;
      allz   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      if (baud_tick_i) begin
        case (st)
          S_IDLE: begin
            tcnt <= '0;
            if (rx_s) locked <= 1'b0;
            else if (!locked) st <= S_START;
          end
          S_START: begin
            if (tcnt == MID) begin
              tcnt <= '0;
              if (rx_s) st <= S_IDLE;
              else begin
                st   <= S_DATA;
                bitn <= '0;
                allz <= 1'b1;
              end
            end else tcnt <= tcnt + 1'b1;
          end
          S_DATA: begin
            if (tcnt == LAST) begin
              tcnt <= '0;
              shr  <= {rx_s, shr[7:1]};
              allz <= allz & !rx_s;
              bitn <= bitn + 1'b1;
              if (bitn == 3'd7) st <= par_en_i ? S_PAR : S_STOP;
            end else tcnt <= tcnt + 1'b1;
          end
          S_PAR: begin
            if (tcnt == LAST) begin
              tcnt  <= '0;
              par_q <= rx_s;
              allz  <= allz & !rx_s;
              st    <= S_STOP;
            end else tcnt <= tcnt + 1'b1;
          end
          S_STOP: begin
            if (tcnt == LAST) begin
              tcnt   <= '0;
              locked <= fe;
              st     <= S_IDLE;
            end else tcnt <= tcnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      err_o <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      err_o <= done && (fe || pe);
      if (push) begin
        mem[wp] <= word;
        wp      <= wp + 1'b1;
      end else if (ovr) begin
        mem[wp - 1'b1][11] <= 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end
endmodule

// File: rtl/uart_rx_errfifo_chk.sv
module uart_rx_errfifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [11:0]              rd_data_o,
  input logic                     rx_avail_o,
  input logic                     err_o,
  input logic                     idle,
  input logic                     locked,
  input logic [$clog2(DEPTH):0]   count
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) count <= ($clog2(DEPTH)+1)'(DEPTH)); // R7
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst) err_o |=> !err_o); // R9
  AST_BRK_ZERO_DATA: assert property (@(posedge clk) disable iff (rst) (rx_avail_o && rd_data_o[10]) |-> (rd_data_o[7:0] == 8'h00 && rd_data_o[8] && !rd_data_o[9])); // R5
  AST_LOCK_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst) (idle && locked) |=> idle); // R6
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst) !rx_avail_o |-> (rd_data_o == 12'h000)); // R10
endmodule

bind uart_rx_errfifo uart_rx_errfifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .rd_data_o(rd_data_o), .rx_avail_o(rx_avail_o),
  .err_o(err_o), .idle(idle), .locked(locked), .count(count)
);

// File: tb/uart_rx_errfifo_tb.sv
module uart_rx_errfifo_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx = 1'b1;
  logic tick = 1'b1;
  logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic rd = 1'b0;
  logic [11:0] rd_data;
  logic avail, err;
  int checks = 0, fails = 0, err_seen = 0;

  always #5 clk = ~clk;

  uart_rx_errfifo dut_i (
    .clk(clk), .rst(rst), .rx_i(rx), .baud_tick_i(tick),
    .par_en_i(par_en), .par_even_i(par_even), .par_stick_i(par_stick),
    .rd_i(rd), .rd_data_o(rd_data), .rx_avail_o(avail), .err_o(err)
  );

  always @(posedge clk) if (!rst && err) err_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk);
    rx = b;
    repeat (15) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic wpar, input logic pb, input logic stopv);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (wpar) drive_bit(pb);
    drive_bit(stopv);
    drive_bit(1'b1);
  endtask

  task automatic read_check(input string req, input logic [11:0] exp);
    @(negedge clk);
    chk({req, " avail"}, int'(avail), 1);
    chk(req, int'(rd_data), int'(exp));
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e0;
    logic pexp;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 avail", int'(avail), 0);
    chk("R10 data", int'(rd_data), 0);
    chk("R10 err", int'(err), 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    // R2 every data value, parity off
    for (int v = 0; v < 256; v++) begin
      e0 = err_seen;
      send_frame(8'(v), 1'b0, 1'b0, 1'b1);
      read_check("R2 data sweep", {4'h0, 8'(v)});
      chk("R9 no pulse clean", err_seen - e0, 0);
    end

    // R4 parity modes, good and bad parity
    par_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      par_even = m[0];
      par_stick = m[1];
      for (int i = 0; i < 32; i++) begin
        for (int bad = 0; bad < 2; bad++) begin
          d = 8'((i * 37 + m * 11 + 1) & 255);
          pexp = par_stick ? ~par_even : (par_even ? ^d : ~(^d));
          e0 = err_seen;
          send_frame(d, 1'b1, pexp ^ bad[0], 1'b1);
          read_check("R4 parity", {2'b00, bad[0], 1'b0, d});
          chk("R9 parity pulse", err_seen - e0, bad);
        end
      end
    end
    par_en = 1'b0;

    // R3 frame error with R6 lock released by idle high
    foreach (d[k]) begin end
    for (int j = 0; j < 3; j++) begin
      d = (j == 0) ? 8'h81 : (j == 1) ? 8'hFF : 8'h01;
      e0 = err_seen;
      send_frame(d, 1'b0, 1'b0, 1'b0);
      read_check("R3 frame error", {4'b0001, d});
      chk("R9 frame pulse", err_seen - e0, 1);
    end

    // R5 break: single zero word, then R6 lockout while low
    e0 = err_seen;
    @(negedge clk);
    rx = 1'b0;
    repeat (14 * 16) @(negedge clk);
    read_check("R5 break word", 12'h500);
    chk("R9 break pulse", err_seen - e0, 1);
    repeat (30 * 16) @(negedge clk);
    chk("R6 no word while low", int'(avail), 0);
    chk("R5 single pulse", err_seen - e0, 1);
    drive_bit(1'b1);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1);
    read_check("R6 resume after high", 12'h03C);

    // R1 short low glitch rejected
    @(negedge clk);
    rx = 1'b0;
    repeat (5) @(negedge clk);
    rx = 1'b1;
    repeat (60) @(negedge clk);
    chk("R1 glitch ignored", int'(avail), 0);

    // R7 order and R8 overrun on 17th character
    for (int k = 0; k < 17; k++) send_frame(8'(8'h40 + k), 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 16; k++)
      read_check(k == 15 ? "R8 overrun mark" : "R7 fifo order",
                 {(k == 15), 3'b000, 8'(8'h40 + k)});
    @(negedge clk);
    chk("R8 discarded char", int'(avail), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule